// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block resolves a translation miss. When the translation cache reports that it has no mapping for a virtual page, the walker locates the page's entry in a one-level page table in main memory and reads that entry over a request/response memory port. The entry address is the table base plus the virtual page number scaled by the entry size, which is four bytes. After the word returns, the walker checks its present flag. If the page is resident, the walker sends the frame number and permission bits to the translation cache as a fill. If the page is not resident, it signals a page fault for the operating system to handle.

Only one walk is in progress at any time. The walker accepts a new miss only when it is idle. It holds `busy` high from the cycle after acceptance up to and including the cycle of its single result pulse. The memory port may stall the request and may return the data after any number of cycles.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `mem_req_valid`, `fill_valid` and `fault_valid` are low and `miss_ready` is high.
- R2: The walker samples `table_base` and `miss_vpn` in the cycle a miss is accepted. The address it requests is table_base + 4 * miss_vpn, modulo 2^PA_W. Later changes to `table_base` do not affect that walk.
- R3: The walker raises `mem_req_valid` in the cycle after a miss is accepted. It keeps `mem_req_valid` high, with `mem_req_addr` unchanged, until a cycle in which `mem_req_ready` is high.
- R4: After the request handshake, the walker issues no further request and stays busy for as long as `mem_rsp_valid` stays low, however many cycles that takes.
- R5: In the entry word, bit 0 is present, bit 1 is modified, bit 2 is read permission, bit 3 is write permission and bits 31:12 are the frame number. When present is 1, the fill pulse carries bits 31:12 on `fill_frame`, bit 3 on `fill_write`, bit 2 on `fill_read`, bit 1 on `fill_dirty`, and the walk's page number on `fill_vpn`.
- R6: When present is 0, the walker pulses `fault_valid` with the walk's page number on `fault_vpn` and does not pulse `fill_valid`.
- R7: Each walk produces exactly one one-cycle pulse, either on `fill_valid` or on `fault_valid`, never on both.
- R8: `miss_ready` is high exactly when `busy` is low. A miss offered while the walker is busy is not accepted and does not change the walk in progress.
- R9: The result pulse comes in the cycle directly after the cycle in which `mem_rsp_valid` is sampled high for the outstanding request. The walker is idle again in the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| miss_valid | input | 1 | A translation miss is offered |
| miss_ready | output | 1 | Walker is idle and accepts a miss |
| miss_vpn | input | VPN_W | Virtual page number of the miss |
| table_base | input | PA_W | Byte address of the start of the page table |
| mem_req_valid | output | 1 | Read request is pending |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_req_addr | output | PA_W | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data is returned this cycle |
| mem_rsp_data | input | 32 | Returned entry word |
| busy | output | 1 | A walk is in progress |
| fill_valid | output | 1 | One-cycle fill pulse for a resident page |
| fill_vpn | output | VPN_W | Page number of the fill |
| fill_frame | output | 20 | Physical frame number of the fill |
| fill_write | output | 1 | Write permission of the fill |
| fill_read | output | 1 | Read permission of the fill |
| fill_dirty | output | 1 | Modified flag of the fill |
| fault_valid | output | 1 | One-cycle page fault pulse |
| fault_vpn | output | VPN_W | Page number that faulted |

## Verification
The assertions assume a memory that sends exactly one response per accepted request, and only after that request's handshake. The timing check from response to result is therefore tied to a walk that the checker knows to be outstanding. The bench's memory model schedules one response per handshake, after one to four cycles, with an occasional forty-cycle wait. It never sends data when no request is open. Misses are offered freely, including while the walker is busy, and the table base changes during walks. These are the input patterns that the sampling and ignore rules cover.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    // Entry word layout: field positions are decoded by the walker
    localparam int PTE_W       = 32;
    localparam int FRAME_LSB   = 12;
    localparam int FRAME_W     = PTE_W - FRAME_LSB;
    localparam int BIT_PRESENT = 0;
    localparam int BIT_DIRTY   = 1;
    localparam int BIT_READ    = 2;
    localparam int BIT_WRITE   = 3;

    typedef enum logic [1:0] {
        WK_IDLE   = 2'd0,
        WK_ISSUE  = 2'd1,
        WK_AWAIT  = 2'd2,
        WK_REPORT = 2'd3
    } walk_state_e;

    typedef struct packed {
        logic [FRAME_W-1:0] frame;
        logic               wr;
        logic               rd;
        logic               dirty;
        logic               present;
    } pte_fields_t;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int VPN_W       = 20,
    parameter int PA_W        = 32,
    parameter int ENTRY_BYTES = 4
) (
    input  logic [PA_W-1:0]  base,
    input  logic [VPN_W-1:0] vpn,
    output logic [PA_W-1:0]  entry_addr
);
    localparam int SHIFT = $clog2(ENTRY_BYTES);

    logic [PA_W-1:0] vpn_wide;
    logic [PA_W-1:0] byte_offset;

    always_comb begin
        vpn_wide    = PA_W'(vpn);
        byte_offset = vpn_wide << SHIFT;
        entry_addr  = base + byte_offset;
    end

endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] raw,
    output pte_fields_t      fields
);
    always_comb begin
        fields.frame   = raw[PTE_W-1:FRAME_LSB];
        fields.wr      = raw[BIT_WRITE];
        fields.rd      = raw[BIT_READ];
        fields.dirty   = raw[BIT_DIRTY];
        fields.present = raw[BIT_PRESENT];
    end

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
    import ptw_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PA_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_valid,
    input  logic [VPN_W-1:0] miss_vpn,
    input  logic [PA_W-1:0]  entry_addr,
    output logic             miss_ready,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             busy,
    output logic             report,
    output logic [VPN_W-1:0] walk_vpn,
    output logic [PTE_W-1:0] walk_pte
);
    typedef struct packed {
        walk_state_e      state;
        logic [VPN_W-1:0] vpn;
        logic [PA_W-1:0]  addr;
        logic [PTE_W-1:0] pte;
    } walk_regs_t;

    walk_regs_t cur_q;
    walk_regs_t nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.state)
            WK_IDLE: begin
                if (miss_valid) begin
                    nxt_d.state = WK_ISSUE;
                    nxt_d.vpn   = miss_vpn;
                    nxt_d.addr  = entry_addr;
                end
            end
            WK_ISSUE: begin
                if (mem_req_ready) begin
                    nxt_d.state = WK_AWAIT;
                end
            end
            WK_AWAIT: begin
                if (mem_rsp_valid) begin
                    nxt_d.state = WK_REPORT;
                    nxt_d.pte   = mem_rsp_data;
                end
            end
            WK_REPORT: begin
                nxt_d.state = WK_IDLE;
            end
            default: begin
                nxt_d.state = WK_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: WK_IDLE, vpn: '0, addr: '0, pte: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        miss_ready    = (cur_q.state == WK_IDLE);
        busy          = (cur_q.state != WK_IDLE);
        mem_req_valid = (cur_q.state == WK_ISSUE);
        mem_req_addr  = cur_q.addr;
        report        = (cur_q.state == WK_REPORT);
        walk_vpn      = cur_q.vpn;
        walk_pte      = cur_q.pte;
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int VPN_W       = 20,
    parameter int PA_W        = 32,
    parameter int ENTRY_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               miss_valid,
    output logic               miss_ready,
    input  logic [VPN_W-1:0]   miss_vpn,
    input  logic [PA_W-1:0]    table_base,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [31:0]        mem_rsp_data,
    output logic               busy,
    output logic               fill_valid,
    output logic [VPN_W-1:0]   fill_vpn,
    output logic [19:0]        fill_frame,
    output logic               fill_write,
    output logic               fill_read,
    output logic               fill_dirty,
    output logic               fault_valid,
    output logic [VPN_W-1:0]   fault_vpn
);
    logic [PA_W-1:0]  entry_addr;
    logic             report;
    logic [VPN_W-1:0] walk_vpn;
    logic [PTE_W-1:0] walk_pte;
    pte_fields_t      fields;

    ptw_addr_gen #(
        .VPN_W       (VPN_W),
        .PA_W        (PA_W),
        .ENTRY_BYTES (ENTRY_BYTES)
    ) u_addr (
        .base       (table_base),
        .vpn        (miss_vpn),
        .entry_addr (entry_addr)
    );

    ptw_ctrl #(
        .VPN_W (VPN_W),
        .PA_W  (PA_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .miss_valid    (miss_valid),
        .miss_vpn      (miss_vpn),
        .entry_addr    (entry_addr),
        .miss_ready    (miss_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .busy          (busy),
        .report        (report),
        .walk_vpn      (walk_vpn),
        .walk_pte      (walk_pte)
    );

    ptw_pte_decode u_dec (
        .raw    (walk_pte),
        .fields (fields)
    );

    always_comb begin
        fill_valid  = report && fields.present;
        fault_valid = report && !fields.present;
        fill_vpn    = walk_vpn;
        fault_vpn   = walk_vpn;
        fill_frame  = fields.frame;
        fill_write  = fields.wr;
        fill_read   = fields.rd;
        fill_dirty  = fields.dirty;
    end

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int VPN_W       = 20,
    parameter int PA_W        = 32,
    parameter int ENTRY_BYTES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             miss_valid,
    input logic             miss_ready,
    input logic [VPN_W-1:0] miss_vpn,
    input logic [PA_W-1:0]  table_base,
    input logic             mem_req_valid,
    input logic             mem_req_ready,
    input logic [PA_W-1:0]  mem_req_addr,
    input logic             mem_rsp_valid,
    input logic             busy,
    input logic             fill_valid,
    input logic [VPN_W-1:0] fill_vpn,
    input logic             fault_valid,
    input logic [VPN_W-1:0] fault_vpn
);
    logic             walk_open;
    logic [PA_W-1:0]  exp_addr;
    logic [VPN_W-1:0] exp_vpn;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_open <= 1'b0;
            exp_addr  <= '0;
            exp_vpn   <= '0;
        end else begin
            if (miss_valid && miss_ready) begin
                exp_addr <= table_base + PA_W'(miss_vpn) * PA_W'(ENTRY_BYTES);
                exp_vpn  <= miss_vpn;
            end
            if (mem_req_valid && mem_req_ready) begin
                walk_open <= 1'b1;
            end else if (walk_open && mem_rsp_valid) begin
                walk_open <= 1'b0;
            end
        end
    end

    AST_ADDR_FORMED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr == exp_addr); // R2
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R3
    AST_OPEN_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        walk_open |-> !mem_req_valid && busy); // R4
    AST_FILL_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |-> fill_vpn == exp_vpn); // R5
    AST_FAULT_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> fault_vpn == exp_vpn); // R6
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_valid && fault_valid)); // R7
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid || fault_valid |=> !fill_valid && !fault_valid && !busy); // R7
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid && miss_ready |=> busy && !miss_ready); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req_valid && !fill_valid && !fault_valid); // R8
    AST_RSP_TO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_open && mem_rsp_valid |=> fill_valid || fault_valid); // R9

endmodule

bind pt_walker pt_walker_chk #(
    .VPN_W       (VPN_W),
    .PA_W        (PA_W),
    .ENTRY_BYTES (ENTRY_BYTES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .miss_ready    (miss_ready),
    .miss_vpn      (miss_vpn),
    .table_base    (table_base),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .busy          (busy),
    .fill_valid    (fill_valid),
    .fill_vpn      (fill_vpn),
    .fault_valid   (fault_valid),
    .fault_vpn     (fault_vpn)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
    localparam int CLK_PERIOD = 10;
    localparam int VPN_W      = 20;
    localparam int PA_W       = 32;
    localparam int RUN_CYCLES = 4000;
    localparam int WDOG_LIMIT = 300;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             miss_valid;
    logic             miss_ready;
    logic [VPN_W-1:0] miss_vpn;
    logic [PA_W-1:0]  table_base;
    logic             mem_req_valid;
    logic             mem_req_ready;
    logic [PA_W-1:0]  mem_req_addr;
    logic             mem_rsp_valid;
    logic [31:0]      mem_rsp_data;
    logic             busy;
    logic             fill_valid;
    logic [VPN_W-1:0] fill_vpn;
    logic [19:0]      fill_frame;
    logic             fill_write;
    logic             fill_read;
    logic             fill_dirty;
    logic             fault_valid;
    logic [VPN_W-1:0] fault_vpn;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pt_walker #(.VPN_W(VPN_W), .PA_W(PA_W), .ENTRY_BYTES(4)) u0 (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_vpn(miss_vpn),
        .table_base(table_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .busy(busy),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_frame(fill_frame),
        .fill_write(fill_write), .fill_read(fill_read), .fill_dirty(fill_dirty),
        .fault_valid(fault_valid), .fault_vpn(fault_vpn)
    );

    int checks = 0;
    int errors = 0;

    // reference model: phase 0 idle, 1 request, 2 awaiting data, 3 result
    int          m_phase = 0;
    logic [19:0] m_vpn   = '0;
    logic [31:0] m_addr  = '0;
    logic [31:0] m_data  = '0;
    // memory responder
    int          r_cnt   = 0;
    logic [31:0] r_addr  = '0;
    // stimulus
    logic [31:0] lfsr    = 32'h1D87_2C4B;
    int          walks   = 0;
    int          n_fill  = 0;
    int          n_fault = 0;
    int          n_long  = 0;
    int          stall   = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] table_word(input logic [31:0] a);
        return {a[23:4] ^ 20'hA5C3F, a[11:4], a[5:2] ^ a[9:6]};
    endfunction

    task automatic step_lfsr();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    endtask

    task automatic cycle(input int cyc);
        bit exp_fill;
        bit exp_fault;
        int lat;
        // drive inputs for the coming edge
        step_lfsr();
        if (cyc % 97 == 13) table_base = {lfsr[31:14], 14'h0} + {lfsr[13:4], 2'b00};
        miss_valid    = lfsr[0] | lfsr[3];
        miss_vpn      = lfsr[27:8];
        mem_req_ready = lfsr[2] | lfsr[5];
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = lfsr ^ 32'h3C3C_0F0F;
        if (r_cnt > 0) begin
            r_cnt--;
            if (r_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = table_word(r_addr);
            end
        end
        #1;
        // compare against the model
        exp_fill  = (m_phase == 3) && m_data[0];
        exp_fault = (m_phase == 3) && !m_data[0];
        check(busy == (m_phase != 0), "R8 busy", 64'(busy), 64'(m_phase != 0));
        check(miss_ready == (m_phase == 0), "R8 miss_ready", 64'(miss_ready), 64'(m_phase == 0));
        check(mem_req_valid == (m_phase == 1), "R3,R4 mem_req_valid", 64'(mem_req_valid), 64'(m_phase == 1));
        if (m_phase == 1)
            check(mem_req_addr == m_addr, "R2 mem_req_addr", 64'(mem_req_addr), 64'(m_addr));
        check(fill_valid == exp_fill, "R7,R9 fill_valid", 64'(fill_valid), 64'(exp_fill));
        check(fault_valid == exp_fault, "R6,R9 fault_valid", 64'(fault_valid), 64'(exp_fault));
        if (exp_fill) begin
            n_fill++;
            check(fill_frame == m_data[31:12], "R5 fill_frame", 64'(fill_frame), 64'(m_data[31:12]));
            check(fill_write == m_data[3], "R5 fill_write", 64'(fill_write), 64'(m_data[3]));
            check(fill_read == m_data[2], "R5 fill_read", 64'(fill_read), 64'(m_data[2]));
            check(fill_dirty == m_data[1], "R5 fill_dirty", 64'(fill_dirty), 64'(m_data[1]));
            check(fill_vpn == m_vpn, "R5 fill_vpn", 64'(fill_vpn), 64'(m_vpn));
        end
        if (exp_fault) begin
            n_fault++;
            check(fault_vpn == m_vpn, "R6 fault_vpn", 64'(fault_vpn), 64'(m_vpn));
        end
        // advance the model across the coming edge
        case (m_phase)
            0: if (miss_valid) begin
                m_phase = 1;
                m_vpn   = miss_vpn;
                m_addr  = table_base + {10'd0, miss_vpn, 2'b00};
            end
            1: if (mem_req_ready) begin
                m_phase = 2;
                lat     = int'(lfsr[7:6]) + 1;
                if (walks % 13 == 5) begin
                    lat = 40;
                    n_long++;
                end
                r_cnt  = lat;
                r_addr = m_addr;
            end
            2: if (mem_rsp_valid) begin
                m_phase = 3;
                m_data  = mem_rsp_data;
                walks++;
            end
            default: m_phase = 0;
        endcase
        stall = (m_phase == 0) ? 0 : stall + 1;
    endtask

    initial begin
        rst_n         = 1'b0;
        miss_valid    = 1'b0;
        miss_vpn      = '0;
        table_base    = 32'h0004_0000;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy", 64'(busy), 64'd0);
        check(miss_ready == 1'b1, "R1 miss_ready", 64'(miss_ready), 64'd1);
        check(mem_req_valid == 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
        check(fill_valid == 1'b0, "R1 fill_valid", 64'(fill_valid), 64'd0);
        check(fault_valid == 1'b0, "R1 fault_valid", 64'(fault_valid), 64'd0);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
            @(negedge clk);
            cycle(cyc);
            if (stall > WDOG_LIMIT) begin
                check(1'b0, "R4 watchdog", 64'(stall), 64'(WDOG_LIMIT));
                break;
            end
        end
        // coverage of both outcomes and of long memory waits
        check(n_fill > 0, "R5 fills seen", 64'(n_fill), 64'd1);
        check(n_fault > 0, "R6 faults seen", 64'(n_fault), 64'd1);
        check(n_long > 0, "R4 long waits seen", 64'(n_long), 64'd1);
        check(walks > 20, "R7 walks completed", 64'(walks), 64'd21);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule